// File: doc/BRIEF.md
# DDR Write Burst Serializer

This block turns one write burst, handed over by a memory controller as eight parallel phases of 32-bit write data, into the frame sequence for a 16-lane double-data-rate data bus. Each system cycle it presents a 16-beat frame for the DQ lanes, a 16-beat frame for each strobe lane and a 16-beat frame for the data-mask lanes. A downstream fixed-ratio serializer shifts these frames out beat 0 first. Frames use a beat-major layout: `dq_beats[b*16 +: 16]` is beat `b` across all lanes, and bit `b` of a strobe lane is that lane's level in beat `b`.

A write enable on any phase arms exactly one burst. The write data is taken from the phases `WR_LAT` cycles after the enable, and only in that cycle. The data goes out in the following cycle. A strobe preamble precedes the data frame and a postamble follows it. The DQ output-enable covers those three frames and nothing else. The controller owns the timing of the transfer, so no stream handshake applies: there is no back-pressure, and the block accepts every input in the cycle it arrives. The data-mask outputs stay low because masking is not provided.

Top module: `wr_burst_serializer`

## Requirements
- R1: A burst is armed when at least one bit of `dfi_wrdata_en` is high in a cycle N. Any one bit is enough, and all bits set arm a single burst. When every bit is low, no burst starts.
- R2: For an enable in cycle N, the block samples `dfi_wrdata` in cycle N+WR_LAT and shows the serialized frame on `dq_beats` throughout cycle N+WR_LAT+1. WR_LAT defaults to 2.
- R3: Phase p occupies `dfi_wrdata[p*32 +: 32]`. Its low 16 bits become beat 2p and its high 16 bits become beat 2p+1.
- R4: Write data presented in any cycle other than N+WR_LAT never reaches `dq_beats`. `dq_beats` is all zero in every cycle that is not a burst frame.
- R5: In cycle N+WR_LAT, each strobe lane carries the preamble frame 16'hA0AA. Bit b is beat b, so the beats are 0101 0101 0000 0101 from beat 0.
- R6: In cycle N+WR_LAT+1, each strobe lane carries the toggling frame 16'hAAAA. In cycle N+WR_LAT+2 it carries the postamble frame 16'hAAA8 (beats 0001 0101 0101 0101).
- R7: Outside the write window, each strobe lane idles with the toggling frame 16'hAAAA. Both strobe lanes are always identical.
- R8: `dmi_beats` is zero in every cycle.
- R9: `dq_oe` is high in cycles N+WR_LAT through N+WR_LAT+2 and low otherwise. It rises only on a preamble frame and falls only after a postamble frame.
- R10: While reset is held and directly after it, `dq_beats` is zero, `dq_oe` is low and the strobe lanes show the idle frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dfi_wrdata_en | input | 8 | Per-phase write enable |
| dfi_wrdata | input | 256 | Eight phases of 32-bit write data, phase p at [p*32 +: 32] |
| dq_beats | output | 256 | DQ frame, beat b at [b*16 +: 16] |
| dq_oe | output | 1 | Output-enable for the DQ tristate |
| dqs_beats | output | 32 | Strobe frames, lane s at [s*16 +: 16], bit = beat |
| dmi_beats | output | 32 | Data-mask frames, always zero |

## Verification
The bench runs bursts armed by a single low phase bit, a single high phase bit and all eight bits. These runs show that any phase arms the transfer and that all bits set still give only one burst. Every phase word has distinct low and high halves, so a swapped beat order or a shifted phase shows up as a data mismatch. Some runs put noise data on the bus in the enable cycle, the cycle after it and the cycle after the data cycle. A final run drives data with no enable at all. Together these separate correct data-cycle selection from designs that pass data through or latch it at the wrong latency.

// File: rtl/wrser_pkg.sv
package wrser_pkg;

  typedef enum logic [1:0] {
    FRM_IDLE  = 2'd0,
    FRM_PRE   = 2'd1,
    FRM_BURST = 2'd2,
    FRM_POST  = 2'd3
  } frame_kind_e;

  // Strobe level per beat, beat 0 in bit 0. Odd beats high while toggling.
  function automatic logic [63:0] strobe_frame(frame_kind_e kind, int beats);
    logic [63:0] f;
    f = '0;
    for (int b = 0; b < beats; b++) begin
      case (kind)
        FRM_PRE:  f[b] = (b % 2 == 1) && ((b < beats / 2) || (b >= beats - 3));
        FRM_POST: f[b] = (b % 2 == 1) && (b >= 3);
        default:  f[b] = (b % 2 == 1);
      endcase
    end
    return f;
  endfunction

endpackage

// File: rtl/wrser_arm_pipe.sv
module wrser_arm_pipe #(
  parameter int PHASES = 8,
  parameter int WR_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] wr_en,
  output logic              sel_pre,
  output logic              sel_burst,
  output logic              sel_post
);
  logic            arm;
  logic [WR_LAT:0] hist_q;
  logic [WR_LAT+1:0] tap;   // tap[k]: enable seen k cycles ago

  assign arm = |wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[WR_LAT-1:0], arm};
  end

  assign tap       = {hist_q, arm};
  assign sel_pre   = tap[WR_LAT-1];
  assign sel_burst = tap[WR_LAT];
  assign sel_post  = tap[WR_LAT+1];
endmodule

// File: rtl/wrser_beat_pack.sv
module wrser_beat_pack #(
  parameter int PHASES = 8,
  parameter int DQ_W   = 16
) (
  input  logic [PHASES*2*DQ_W-1:0] words,
  output logic [PHASES*2*DQ_W-1:0] beats
);
  localparam int WORD_W = 2 * DQ_W;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    // low half-word first, then high half-word
    assign beats[(2*p)*DQ_W   +: DQ_W] = words[p*WORD_W        +: DQ_W];
    assign beats[(2*p+1)*DQ_W +: DQ_W] = words[p*WORD_W + DQ_W +: DQ_W];
  end
endmodule

// File: rtl/wrser_strobe_gen.sv
module wrser_strobe_gen
  import wrser_pkg::*;
#(
  parameter int BEATS = 16,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_pre,
  input  logic               sel_burst,
  input  logic               sel_post,
  output logic [LANES*BEATS-1:0] dqs_beats
);
  localparam logic [63:0] F_IDLE  = strobe_frame(FRM_IDLE, BEATS);
  localparam logic [63:0] F_PRE   = strobe_frame(FRM_PRE, BEATS);
  localparam logic [63:0] F_BURST = strobe_frame(FRM_BURST, BEATS);
  localparam logic [63:0] F_POST  = strobe_frame(FRM_POST, BEATS);

  frame_kind_e      kind_d;
  logic [BEATS-1:0] frame_q;
  logic [63:0]      frame_d;

  always_comb begin
    if (sel_burst)     kind_d = FRM_BURST;
    else if (sel_post) kind_d = FRM_POST;
    else if (sel_pre)  kind_d = FRM_PRE;
    else               kind_d = FRM_IDLE;
    case (kind_d)
      FRM_PRE:   frame_d = F_PRE;
      FRM_BURST: frame_d = F_BURST;
      FRM_POST:  frame_d = F_POST;
      default:   frame_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= F_IDLE[BEATS-1:0];
    else        frame_q <= frame_d[BEATS-1:0];
  end

  for (genvar s = 0; s < LANES; s++) begin : g_lane
    assign dqs_beats[s*BEATS +: BEATS] = frame_q;
  end
endmodule

// File: rtl/wr_burst_serializer.sv
module wr_burst_serializer
  import wrser_pkg::*;
#(
  parameter int PHASES    = 8,
  parameter int DQ_W      = 16,
  parameter int DQS_LANES = 2,
  parameter int WR_LAT    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PHASES-1:0]            dfi_wrdata_en,
  input  logic [PHASES*2*DQ_W-1:0]     dfi_wrdata,
  output logic [PHASES*2*DQ_W-1:0]     dq_beats,
  output logic                         dq_oe,
  output logic [DQS_LANES*2*PHASES-1:0] dqs_beats,
  output logic [DQS_LANES*2*PHASES-1:0] dmi_beats
);
  localparam int BEATS   = 2 * PHASES;
  localparam int FRAME_W = BEATS * DQ_W;
  localparam logic [63:0] CHK_PRE   = strobe_frame(FRM_PRE, BEATS);
  localparam logic [63:0] CHK_BURST = strobe_frame(FRM_BURST, BEATS);
  localparam logic [63:0] CHK_POST  = strobe_frame(FRM_POST, BEATS);

  logic               sel_pre, sel_burst, sel_post;
  logic [FRAME_W-1:0] packed_beats;
  logic [FRAME_W-1:0] dq_q;
  logic               oe_q;

  wrser_arm_pipe #(.PHASES(PHASES), .WR_LAT(WR_LAT)) u_arm (
    .clk(clk), .rst_n(rst_n), .wr_en(dfi_wrdata_en),
    .sel_pre(sel_pre), .sel_burst(sel_burst), .sel_post(sel_post)
  );

  wrser_beat_pack #(.PHASES(PHASES), .DQ_W(DQ_W)) u_pack (
    .words(dfi_wrdata), .beats(packed_beats)
  );

  wrser_strobe_gen #(.BEATS(BEATS), .LANES(DQS_LANES)) u_stb (
    .clk(clk), .rst_n(rst_n), .sel_pre(sel_pre), .sel_burst(sel_burst),
    .sel_post(sel_post), .dqs_beats(dqs_beats)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q <= '0;
      oe_q <= 1'b0;
    end else begin
      dq_q <= sel_burst ? packed_beats : '0;
      oe_q <= sel_pre | sel_burst | sel_post;
    end
  end

  assign dq_beats  = dq_q;
  assign dq_oe     = oe_q;
  assign dmi_beats = '0;

  AST_DQ_ONLY_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_beats != '0) |-> dq_oe); // R4
  AST_PRE_THEN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_beats[BEATS-1:0] == CHK_PRE[BEATS-1:0]) |=>
      (dqs_beats[BEATS-1:0] == CHK_BURST[BEATS-1:0]) && dq_oe); // R6
  AST_POST_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_beats[BEATS-1:0] == CHK_POST[BEATS-1:0]) |->
      ($past(dqs_beats[BEATS-1:0]) == CHK_BURST[BEATS-1:0])); // R6
  AST_OE_RISE_ON_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (dqs_beats[BEATS-1:0] == CHK_PRE[BEATS-1:0])); // R9
  AST_OE_FALL_AFTER_POST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> ($past(dqs_beats[BEATS-1:0]) == CHK_POST[BEATS-1:0])); // R9
endmodule

// File: tb/wr_burst_serializer_tb.sv
module wr_burst_serializer_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   en = '0;
  logic [255:0] wdata = '0;
  logic [255:0] dq;
  logic         oe;
  logic [31:0]  dqs;
  logic [31:0]  dmi;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  wr_burst_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .dfi_wrdata_en(en), .dfi_wrdata(wdata),
    .dq_beats(dq), .dq_oe(oe), .dqs_beats(dqs), .dmi_beats(dmi)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_words(input logic [15:0] seed);
    logic [255:0] w;
    for (int p = 0; p < 8; p++) begin
      logic [15:0] lo;
      lo = seed ^ (16'(p) * 16'h0101);
      w[p*32 +: 32] = {lo ^ 16'hF00F, lo};
    end
    return w;
  endfunction

  function automatic logic [255:0] expect_beats(input logic [255:0] w);
    logic [255:0] f;
    for (int b = 0; b < 16; b++)
      f[b*16 +: 16] = w[(b/2)*32 + (b%2)*16 +: 16];
    return f;
  endfunction

  task automatic chk_frame(input string req, input logic [15:0] stb,
                           input bit exp_oe, input logic [255:0] exp_dq);
    chk(dqs[15:0] == stb, req, "strobe lane0", 256'(dqs[15:0]), 256'(stb));
    chk(dqs[31:16] == dqs[15:0], "R7", "strobe lanes equal", 256'(dqs[31:16]), 256'(dqs[15:0]));
    chk(oe == exp_oe, "R9", "dq_oe", 256'(oe), 256'(exp_oe));
    chk(dq == exp_dq, req, "dq frame", dq, exp_dq);
    chk(dmi == '0, "R8", "dmi", 256'(dmi), 256'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_frame("R10", 16'hAAAA, 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_frame("R10", 16'hAAAA, 1'b0, '0);
  endtask

  // enable in cycle N, data in N+2, frames visible after edges N+1..N+3
  task automatic t_burst(input logic [7:0] en_bits, input logic [15:0] seed, input bit noise);
    logic [255:0] w;
    w = mk_words(seed);
    en = en_bits;                               // R1
    wdata = noise ? mk_words(seed ^ 16'h5A5A) : '0;
    @(negedge clk);
    en = '0;
    chk_frame("R7", 16'hAAAA, 1'b0, '0);
    wdata = noise ? mk_words(seed + 16'd3) : '0;  // R4 ignored
    @(negedge clk);
    chk_frame("R5", 16'hA0AA, 1'b1, '0);
    wdata = w;
    @(negedge clk);
    chk_frame("R2", 16'hAAAA, 1'b1, expect_beats(w));
    chk(dq[15:0] == w[15:0], "R3", "beat0 low half", 256'(dq[15:0]), 256'(w[15:0]));
    chk(dq[31:16] == w[31:16], "R3", "beat1 high half", 256'(dq[31:16]), 256'(w[31:16]));
    wdata = noise ? mk_words(~seed) : '0;
    @(negedge clk);
    chk_frame("R6", 16'hAAA8, 1'b1, '0);
    wdata = '0;
    @(negedge clk);
    chk_frame("R4", 16'hAAAA, 1'b0, '0);
  endtask

  task automatic t_no_enable();
    en = '0;
    for (int i = 0; i < 6; i++) begin
      wdata = mk_words(16'h1234 + 16'(i));
      @(negedge clk);
      chk_frame("R1", 16'hAAAA, 1'b0, '0);
    end
    wdata = '0;
  endtask

  task automatic run_all();
    t_reset();
    t_burst(8'h01, 16'h2222, 1'b0);
    t_burst(8'h80, 16'hC3A5, 1'b1);
    t_burst(8'hFF, 16'h0F1E, 1'b1);
    t_burst(8'h10, 16'hFFFF, 1'b0);
    t_no_enable();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule